// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a slow timebase, delivered as a single-cycle tick enable at a nominal 32768 ticks per second, into a one-cycle strobe that marks each elapsed second. The length of a second is not fixed: it is set by a 16-bit calibration word, and a second lasts exactly (word + 1) ticks. The reset default of 0x7FFF therefore gives exactly 32768 ticks, i.e. no frequency offset. A larger word stretches the second (the clock runs slow), and a smaller word shortens it.

Two candidate words arrive as input ports: one held in a software-written configuration register elsewhere in the chip, and one produced by a hardware measurement engine. A source-select input picks which one is used. The chosen word is captured only at a second boundary, or while counting is disabled, so a second that is already under way is never cut short or stretched by a change. The captured word is presented on an output so that the value actually in use can be read back. A global enable stops the count. The asynchronous active-low reset is synchronised inside the block before it releases any state.

Top module: `sec_prescaler`

## Requirements
- R1: During reset and right after it, the strobe is low, the tick count is zero and the word in use reads 0x7FFF.
- R2: With counting enabled and word W in use, the strobe fires on the (W+1)-th tick after the previous strobe, or after counting was enabled.
- R3: The strobe is high only in a cycle where both the tick input and the enable are high, and it lasts exactly that one system clock cycle.
- R4: While the enable is low no strobe is produced and the tick count is held at zero, so re-enabling starts a full new second.
- R5: Source select 0 chooses the software word and 1 chooses the hardware word; the chosen word is captured in any strobe cycle and in any cycle with the enable low.
- R6: A change to either candidate word or to the source select in any other cycle has no effect on the second under way; the word in use stays unchanged until the next capture.
- R7: The read-back output always equals the word that governs the length of the current second.
- R8: Word 0x0000 gives a strobe on every enabled tick, and word 0xFFFF gives a strobe every 65536 ticks.
- R9: Clock cycles without a tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| tick_i | input | 1 | Single-cycle timebase tick enable, nominally 32768 per second |
| enable_i | input | 1 | Global count enable |
| cal_sel_i | input | 1 | Calibration source: 0 software word, 1 hardware word |
| sw_cal_i | input | 16 | Software-supplied calibration word |
| hw_cal_i | input | 16 | Hardware-measured calibration word |
| sec_pulse_o | output | 1 | One-cycle strobe at the end of each second |
| cal_active_o | output | 16 | Calibration word governing the current second |

## Verification
The two functions that can meet in one cycle are the completion of a second and a change of the calibration source, word or enable. The bench watches its own model for the cycle in which a second will complete and, in that very cycle, alters the selected word, flips the source, or drops the enable. It then judges that the word captured is the one present in the completing cycle, that the following second has exactly that length, and that a drop of the enable in the completing cycle suppresses the strobe and restarts the count.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

  // Source of the calibration word
  typedef enum logic {
    SRC_SW = 1'b0,
    SRC_HW = 1'b1
  } cal_src_e;

endpackage

// File: rtl/sec_prescaler_rst_sync.sv
module sec_prescaler_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/sec_prescaler_cal_source.sv
module sec_prescaler_cal_source
  import sec_prescaler_pkg::*;
#(
  parameter int          CAL_W   = 16,
  parameter logic [CAL_W-1:0] CAL_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sel_i,
  input  logic [CAL_W-1:0] sw_cal_i,
  input  logic [CAL_W-1:0] hw_cal_i,
  output logic [CAL_W-1:0] active_o
);

  cal_src_e         src;
  logic [CAL_W-1:0] chosen;
  logic [CAL_W-1:0] active_q;
  logic [CAL_W-1:0] active_d;

  assign src = cal_src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_HW:  chosen = hw_cal_i;
      default: chosen = sw_cal_i;
    endcase
  end

  // Capture only at a boundary; otherwise hold
  always_comb begin
    active_d = active_q;
    if (load_i) active_d = chosen;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= CAL_RST;
    else         active_q <= active_d;
  end

  assign active_o = active_q;

endmodule

// File: rtl/sec_prescaler_counter.sv
module sec_prescaler_counter #(
  parameter int CAL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] limit_i,
  output logic             wrap_o
);

  logic [CAL_W-1:0] cnt_q;
  logic [CAL_W-1:0] cnt_d;
  logic             at_limit;
  logic             step;

  assign at_limit = (cnt_q == limit_i);
  assign step     = enable_i & tick_i;
  assign wrap_o   = step & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable_i)   cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (step)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CAL_W         = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             cal_sel_i,
  input  logic [CAL_W-1:0] sw_cal_i,
  input  logic [CAL_W-1:0] hw_cal_i,
  output logic             sec_pulse_o,
  output logic [CAL_W-1:0] cal_active_o
);

  localparam logic [CAL_W-1:0] CAL_RST = CAL_W'(TICKS_PER_SEC - 1);

  logic             rst_sync_n;
  logic             wrap;
  logic             cal_load;
  logic [CAL_W-1:0] cal_active;

  sec_prescaler_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // A new word is taken at a second boundary or while idle
  assign cal_load = wrap | ~enable_i;

  sec_prescaler_cal_source #(
    .CAL_W   (CAL_W),
    .CAL_RST (CAL_RST)
  ) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (cal_load),
    .sel_i    (cal_sel_i),
    .sw_cal_i (sw_cal_i),
    .hw_cal_i (hw_cal_i),
    .active_o (cal_active)
  );

  sec_prescaler_counter #(
    .CAL_W (CAL_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .enable_i (enable_i),
    .tick_i   (tick_i),
    .limit_i  (cal_active),
    .wrap_o   (wrap)
  );

  assign sec_pulse_o  = wrap;
  assign cal_active_o = cal_active;

endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
  parameter int CAL_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             tick_i,
  input logic             enable_i,
  input logic             cal_sel_i,
  input logic [CAL_W-1:0] sw_cal_i,
  input logic [CAL_W-1:0] hw_cal_i,
  input logic             sec_pulse_o,
  input logic [CAL_W-1:0] cal_active_o
);

  // Ticks counted since the last boundary, kept independently
  logic [CAL_W:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                          seen_q <= '0;
    else if (!enable_i || sec_pulse_o)   seen_q <= '0;
    else if (tick_i)                     seen_q <= seen_q + 1'b1;
  end

  a_r2_full_second: assert property (@(posedge clk_i) disable iff (!rst_n)
    sec_pulse_o |-> (seen_q == {1'b0, cal_active_o}));

  a_r3_pulse_on_tick: assert property (@(posedge clk_i) disable iff (!rst_n)
    sec_pulse_o |-> tick_i);

  a_r4_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i |-> !sec_pulse_o);

  a_r5_capture_choice: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sec_pulse_o || !enable_i) |=>
      (cal_active_o == $past(cal_sel_i ? hw_cal_i : sw_cal_i)));

  a_r6_hold_mid_second: assert property (@(posedge clk_i) disable iff (!rst_n)
    (enable_i && !sec_pulse_o) |=> $stable(cal_active_o));

endmodule

bind sec_prescaler sec_prescaler_chk #(
  .CAL_W (CAL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sync_n),
  .tick_i       (tick_i),
  .enable_i     (enable_i),
  .cal_sel_i    (cal_sel_i),
  .sw_cal_i     (sw_cal_i),
  .hw_cal_i     (hw_cal_i),
  .sec_pulse_o  (sec_pulse_o),
  .cal_active_o (cal_active_o)
);

// File: tb/sec_prescaler_tb_top.sv
`timescale 1ns/1ps
module sec_prescaler_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        en;
  logic        sel;
  logic [15:0] sw;
  logic [15:0] hw;
  logic        pulse;
  logic [15:0] cal;

  // next-cycle stimulus, applied at the falling edge
  logic        n_en, n_sel, n_rst;
  logic [15:0] n_sw, n_hw;
  int          tick_div;
  int          cyc;
  int          vectors;
  int          fails;
  int          pulses_seen;
  int          coinc_mode;     // 0 none, 1 change word, 2 flip source, 3 disable
  int          coinc_hits;
  string       cur_req;

  // behavioural model state
  int          m_cnt;
  int          m_word;

  sec_prescaler dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .enable_i     (en),
    .cal_sel_i    (sel),
    .sw_cal_i     (sw),
    .hw_cal_i     (hw),
    .sec_pulse_o  (pulse),
    .cal_active_o (cal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit exp_p;
    bit pred;
    int chosen;
    @(negedge clk);
    cyc++;
    rst_n = n_rst;
    en    = n_en;
    sel   = n_sel;
    sw    = n_sw;
    hw    = n_hw;
    tick  = (tick_div == 1) || ((cyc % tick_div) == 0);
    pred  = en && tick && (m_cnt == m_word);
    if (pred && coinc_mode != 0) begin
      coinc_hits++;
      if (coinc_mode == 1) begin n_sw = n_sw + 16'd3; sw = n_sw; end
      if (coinc_mode == 2) begin n_sel = ~n_sel; sel = n_sel; end
      if (coinc_mode == 3) begin n_en = 1'b0; en = 1'b0; end
    end
    #1;
    exp_p = en && tick && (m_cnt == m_word);
    check(cur_req, int'(pulse), int'(exp_p), "second strobe");
    check("R7", int'(cal), m_word, "word in use");
    if (pulse) pulses_seen++;
    // model update for the coming rising edge
    chosen = sel ? int'(hw) : int'(sw);
    if (!rst_n) begin
      m_cnt = 0; m_word = 32'h7FFF;
    end else if (!en) begin
      m_cnt = 0; m_word = chosen;
    end else if (tick) begin
      if (m_cnt == m_word) begin m_cnt = 0; m_word = chosen; end
      else m_cnt++;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    vectors = 0; fails = 0; cyc = 0; pulses_seen = 0;
    coinc_mode = 0; coinc_hits = 0;
    m_cnt = 0; m_word = 32'h7FFF;
    rst_n = 1'b0; en = 1'b0; tick = 1'b0; sel = 1'b0; sw = 16'h7FFF; hw = 16'h7FFF;
    n_rst = 1'b0; n_en = 1'b0; n_sel = 1'b0; n_sw = 16'h7FFF; n_hw = 16'h7FFF;
    tick_div = 1;

    // R1: reset state, ticks present but no strobe
    cur_req = "R1";
    n_en = 1'b1;
    run(4);
    n_en = 1'b0;
    n_rst = 1'b1;
    run(6);

    // R2: basic period, word 4, tick every third cycle
    cur_req = "R2";
    n_sw = 16'd4;
    run(2);
    n_en = 1'b1; tick_div = 3;
    pulses_seen = 0;
    run(75);                              // 25 ticks -> 5 strobes
    check("R2", pulses_seen, 5, "strobes for 25 ticks of word 4");

    // R9: sparse ticks, same word
    cur_req = "R9";
    tick_div = 7;
    run(70);

    // R6: word changes mid-second do not disturb the running second
    cur_req = "R6";
    tick_div = 2;
    for (int k = 0; k < 6; k++) begin
      n_sw = 16'(5 + k);
      run(5);
    end
    n_hw = 16'd2;
    run(20);

    // R5: hardware source
    cur_req = "R5";
    n_sel = 1'b1;
    run(40);
    n_hw = 16'd6;
    run(40);
    n_sel = 1'b0; n_sw = 16'd3;
    run(30);

    // R4: disable with ticks running, then restart
    cur_req = "R4";
    n_en = 1'b0;
    pulses_seen = 0;
    run(20);
    check("R4", pulses_seen, 0, "strobes while disabled");
    n_en = 1'b1;
    run(30);

    // R3: one-cycle strobe under continuous ticks, word 1
    cur_req = "R3";
    n_sw = 16'd1; tick_div = 1;
    run(20);

    // coincidences: change at the completing tick
    cur_req = "R6";
    coinc_mode = 1; tick_div = 2;
    run(80);
    cur_req = "R5";
    n_hw = 16'd3; coinc_mode = 2;
    run(80);
    cur_req = "R4";
    coinc_mode = 3;
    run(30);
    coinc_mode = 0;
    check("R6", int'(coinc_hits >= 3), 1, "coincidence events provoked");

    // R8: word zero strobes on every tick
    cur_req = "R8";
    n_en = 1'b0; n_sel = 1'b0; n_sw = 16'd0; tick_div = 1;
    run(2);
    n_en = 1'b1;
    pulses_seen = 0;
    run(20);
    check("R8", pulses_seen, 20, "strobes with word 0");

    // R8: largest word, 65536 ticks per second
    n_en = 1'b0; n_sw = 16'hFFFF;
    run(2);
    n_en = 1'b1;
    pulses_seen = 0;
    run(131072);
    check("R8", pulses_seen, 2, "strobes over 131072 ticks of word 0xFFFF");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // watchdog
  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule